// File: doc/BRIEF.md
# Packet Bus Address and Data Serializer

This block is the transmit side of a narrow, packet-based memory bus. It has three independent lanes: one carries row addresses, one carries column addresses and one carries data blocks. Each lane takes a wide request through a valid/ready handshake and sends it out as a packet. A packet always lasts four clock cycles and holds eight double-rate beats.

The double-rate transfer is modelled by two beat ports per lane. In each cycle, the "r" port holds the beat for the rising edge and the "f" port holds the beat for the falling edge. Beats go out least significant slice first.

The lanes differ in width:

- The row lane is 3 bits wide and carries a 12-bit address.
- The column lane is 5 bits wide and carries a 20-bit address.
- The data lane is 16 bits wide and carries a 128-bit block by default. A parameter widens it to 18 bits and a 144-bit block, to make room for check bits.

For the two address lanes, the payload fills only the first slices of the packet, and the remaining beats are driven low. A per-lane frame signal marks the four packet cycles. Ready rises in the last cycle of a packet, so packets on a lane can follow each other with no idle cycle.

Top module: `pbs_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every frame output is 0, every ready output is 1 and every beat output is 0.
- R2: A request is taken at a rising edge where valid and ready are both 1. Frame is 1 for exactly the four cycles that follow that edge. It then returns to 0, unless another request was taken at the edge that ends the fourth cycle.
- R3: Slice i of a payload is bits [i*W +: W], where W is the lane width. In packet cycle k (k = 0..3), the rising-edge port carries slice 2k and the falling-edge port carries slice 2k+1.
- R4: On the row lane (W=3, 12-bit payload) and on the column lane (W=5, 20-bit payload), slices 0 to 3 carry the payload and slices 4 to 7 are driven as zero.
- R5: The data lane is 16 bits wide with a 128-bit payload when the check-bit parameter is 0, and 18 bits wide with a 144-bit payload when it is 1. In both cases all eight slices carry payload.
- R6: Ready is 1 whenever frame is 0. During a packet, ready is 0 in cycles 0 to 2 and 1 in cycle 3.
- R7: While ready is 0, valid and the payload inputs are ignored. The packet that goes out next carries the payload present at the edge where the request was actually taken.
- R8: The three lanes run independently. Packets may be in flight on all lanes at once without affecting one another.
- R9: Both beat ports of a lane are 0 in every cycle where that lane's frame is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the beat ports change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | Row request present |
| row_addr | input | 12 | Row address payload |
| row_ready | output | 1 | Row lane can take a request at this edge |
| row_frame | output | 1 | Row packet in progress |
| row_beat_r | output | 3 | Row rising-edge beat |
| row_beat_f | output | 3 | Row falling-edge beat |
| col_valid | input | 1 | Column request present |
| col_addr | input | 20 | Column address payload |
| col_ready | output | 1 | Column lane can take a request at this edge |
| col_frame | output | 1 | Column packet in progress |
| col_beat_r | output | 5 | Column rising-edge beat |
| col_beat_f | output | 5 | Column falling-edge beat |
| data_valid | input | 1 | Data request present |
| data_block | input | 128 | Data block payload (144 with check bits) |
| data_ready | output | 1 | Data lane can take a request at this edge |
| data_frame | output | 1 | Data packet in progress |
| data_beat_r | output | 16 | Data rising-edge beat (18 with check bits) |
| data_beat_f | output | 16 | Data falling-edge beat (18 with check bits) |

## Verification
A wrong cycle count inside a lane shows up at the ports within one packet. The frame pulse is three or five cycles long, or ready rises in the wrong packet cycle, and both are visible no later than the cycle after the fourth packet cycle. A slip in the slice store shows up in the very first packet cycle as a beat that does not match the arithmetic slice of the request. Stale contents left behind after a packet appear as nonzero beats while frame is low, and they are caught in the first idle cycle.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;

    // Fixed packet geometry shared by every lane.
    localparam int CYC_PER_PKT   = 4;
    localparam int BEATS_PER_CYC = 2;
    localparam int BEATS_PER_PKT = CYC_PER_PKT * BEATS_PER_CYC;
    localparam int CYC_CNT_W     = $clog2(CYC_PER_PKT);

    // Data lane width with or without the check-bit extension.
    localparam int DATA_W_PLAIN = 16;
    localparam int DATA_W_CHECK = 18;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } lane_phase_e;

    typedef struct packed {
        lane_phase_e          phase;
        logic [CYC_CNT_W-1:0] cyc;
    } lane_state_t;

    function automatic int data_lane_width(input bit with_check);
        return with_check ? DATA_W_CHECK : DATA_W_PLAIN;
    endfunction

    function automatic int packet_bits(input int lane_w);
        return BEATS_PER_PKT * lane_w;
    endfunction

endpackage

// File: rtl/pbs_frame_ctl.sv
`timescale 1ns/1ps
// Per-lane packet sequencer: tracks the four packet cycles and decides
// when the lane may take the next request.
module pbs_frame_ctl
    import pbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready,
    output logic frame,
    output logic advance
);

    localparam logic [CYC_CNT_W-1:0] LAST_CYC = CYC_CNT_W'(CYC_PER_PKT - 1);

    lane_state_t st_q;
    lane_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.phase = PH_SEND;
            st_d.cyc   = '0;
        end else if (st_q.phase == PH_SEND) begin
            if (st_q.cyc == LAST_CYC) begin
                st_d.phase = PH_IDLE;
                st_d.cyc   = '0;
            end else begin
                st_d.cyc = st_q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, cyc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign frame   = (st_q.phase == PH_SEND);
    assign advance = frame;
    assign ready   = (st_q.phase == PH_IDLE) || (st_q.cyc == LAST_CYC);

endmodule

// File: rtl/pbs_beat_shifter.sv
`timescale 1ns/1ps
// Holds one packet as eight slices and presents two of them per cycle,
// lowest slice first; unused high slices are zero filled.
module pbs_beat_shifter
    import pbs_pkg::*;
#(
    parameter int LANE_W = 3,
    parameter int PAY_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAY_W-1:0]  payload,
    input  logic              advance,
    output logic [LANE_W-1:0] beat_r,
    output logic [LANE_W-1:0] beat_f
);

    localparam int FULL_W  = packet_bits(LANE_W);
    localparam int STEP_W  = BEATS_PER_CYC * LANE_W;

    logic [FULL_W-1:0] padded;
    logic [FULL_W-1:0] slots_q;

    generate
        if (PAY_W < FULL_W) begin : g_pad
            assign padded = {{(FULL_W - PAY_W){1'b0}}, payload};
        end else begin : g_full
            assign padded = payload[FULL_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            slots_q <= '0;
        end else if (load) begin
            slots_q <= padded;
        end else if (advance) begin
            slots_q <= slots_q >> STEP_W;
        end
    end

    assign beat_r = slots_q[0      +: LANE_W];
    assign beat_f = slots_q[LANE_W +: LANE_W];

endmodule

// File: rtl/pbs_lane.sv
`timescale 1ns/1ps
// One serializing lane: handshake, sequencer and slice store.
module pbs_lane
    import pbs_pkg::*;
#(
    parameter int LANE_W = 3,
    parameter int PAY_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PAY_W-1:0]  in_payload,
    output logic              in_ready,
    output logic              out_frame,
    output logic [LANE_W-1:0] out_beat_r,
    output logic [LANE_W-1:0] out_beat_f
);

    logic start;
    logic advance;

    assign start = in_valid && in_ready;

    pbs_frame_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ready   (in_ready),
        .frame   (out_frame),
        .advance (advance)
    );

    pbs_beat_shifter #(
        .LANE_W (LANE_W),
        .PAY_W  (PAY_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .payload (in_payload),
        .advance (advance),
        .beat_r  (out_beat_r),
        .beat_f  (out_beat_f)
    );

endmodule

// File: rtl/pbs_tx.sv
`timescale 1ns/1ps
// Three independent packet lanes: row address, column address, data.
module pbs_tx
    import pbs_pkg::*;
#(
    parameter int ROW_LANE_W = 3,
    parameter int ROW_PAY_W  = 12,
    parameter int COL_LANE_W = 5,
    parameter int COL_PAY_W  = 20,
    parameter bit DATA_CHECK = 1'b0,
    localparam int DATA_LANE_W = data_lane_width(DATA_CHECK),
    localparam int DATA_PAY_W  = packet_bits(DATA_LANE_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   row_valid,
    input  logic [ROW_PAY_W-1:0]   row_addr,
    output logic                   row_ready,
    output logic                   row_frame,
    output logic [ROW_LANE_W-1:0]  row_beat_r,
    output logic [ROW_LANE_W-1:0]  row_beat_f,
    input  logic                   col_valid,
    input  logic [COL_PAY_W-1:0]   col_addr,
    output logic                   col_ready,
    output logic                   col_frame,
    output logic [COL_LANE_W-1:0]  col_beat_r,
    output logic [COL_LANE_W-1:0]  col_beat_f,
    input  logic                   data_valid,
    input  logic [DATA_PAY_W-1:0]  data_block,
    output logic                   data_ready,
    output logic                   data_frame,
    output logic [DATA_LANE_W-1:0] data_beat_r,
    output logic [DATA_LANE_W-1:0] data_beat_f
);

    pbs_lane #(.LANE_W(ROW_LANE_W), .PAY_W(ROW_PAY_W)) u_row (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (row_valid),
        .in_payload (row_addr),
        .in_ready   (row_ready),
        .out_frame  (row_frame),
        .out_beat_r (row_beat_r),
        .out_beat_f (row_beat_f)
    );

    pbs_lane #(.LANE_W(COL_LANE_W), .PAY_W(COL_PAY_W)) u_col (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (col_valid),
        .in_payload (col_addr),
        .in_ready   (col_ready),
        .out_frame  (col_frame),
        .out_beat_r (col_beat_r),
        .out_beat_f (col_beat_f)
    );

    pbs_lane #(.LANE_W(DATA_LANE_W), .PAY_W(DATA_PAY_W)) u_data (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (data_valid),
        .in_payload (data_block),
        .in_ready   (data_ready),
        .out_frame  (data_frame),
        .out_beat_r (data_beat_r),
        .out_beat_f (data_beat_f)
    );

endmodule

// File: rtl/pbs_lane_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for one lane, bound three times into pbs_tx.
module pbs_lane_chk #(
    parameter int LANE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              valid,
    input logic              ready,
    input logic              frame,
    input logic [LANE_W-1:0] beat_r,
    input logic [LANE_W-1:0] beat_f
);

    // Cycles since the request that opened the current packet.
    logic [2:0] age_q;
    logic       take;

    assign take = valid && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (take) begin
            age_q <= '0;
        end else if (frame) begin
            age_q <= age_q + 3'd1;
        end else begin
            age_q <= '0;
        end
    end

    a_r2_take_opens_frame: assert property (@(posedge clk) disable iff (rst)
        take |=> frame);

    a_r2_frame_max_len: assert property (@(posedge clk) disable iff (rst)
        frame |-> (age_q <= 3'd3));

    a_r2_frame_closes: assert property (@(posedge clk) disable iff (rst)
        (frame && age_q == 3'd3 && !take) |=> !frame);

    a_r6_ready_idle: assert property (@(posedge clk) disable iff (rst)
        !frame |-> ready);

    a_r6_ready_last_cycle: assert property (@(posedge clk) disable iff (rst)
        frame |-> (ready == (age_q == 3'd3)));

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !frame |-> (beat_r == '0 && beat_f == '0));

endmodule

bind pbs_tx pbs_lane_chk #(.LANE_W(ROW_LANE_W)) u_chk_row (
    .clk(clk), .rst(rst), .valid(row_valid), .ready(row_ready),
    .frame(row_frame), .beat_r(row_beat_r), .beat_f(row_beat_f)
);

bind pbs_tx pbs_lane_chk #(.LANE_W(COL_LANE_W)) u_chk_col (
    .clk(clk), .rst(rst), .valid(col_valid), .ready(col_ready),
    .frame(col_frame), .beat_r(col_beat_r), .beat_f(col_beat_f)
);

bind pbs_tx pbs_lane_chk #(.LANE_W(DATA_LANE_W)) u_chk_data (
    .clk(clk), .rst(rst), .valid(data_valid), .ready(data_ready),
    .frame(data_frame), .beat_r(data_beat_r), .beat_f(data_beat_f)
);

// File: tb/test_pbs_tx.sv
`timescale 1ns/1ps
module test_pbs_tx;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Default instance: 16-bit data lane.
    logic         row_valid = 0, col_valid = 0, data_valid = 0;
    logic [11:0]  row_addr = '0;
    logic [19:0]  col_addr = '0;
    logic [127:0] data_block = '0;
    logic         row_ready, row_frame, col_ready, col_frame, data_ready, data_frame;
    logic [2:0]   row_beat_r, row_beat_f;
    logic [4:0]   col_beat_r, col_beat_f;
    logic [15:0]  data_beat_r, data_beat_f;

    // Check-bit instance: 18-bit data lane; address lanes unused.
    logic         e_valid = 0;
    logic [143:0] e_block = '0;
    logic         e_ready, e_frame;
    logic [17:0]  e_beat_r, e_beat_f;
    logic         e_row_ready, e_row_frame, e_col_ready, e_col_frame;
    logic [2:0]   e_row_r, e_row_f;
    logic [4:0]   e_col_r, e_col_f;

    pbs_tx i_pbs_tx (
        .clk(clk), .rst(rst),
        .row_valid(row_valid), .row_addr(row_addr), .row_ready(row_ready),
        .row_frame(row_frame), .row_beat_r(row_beat_r), .row_beat_f(row_beat_f),
        .col_valid(col_valid), .col_addr(col_addr), .col_ready(col_ready),
        .col_frame(col_frame), .col_beat_r(col_beat_r), .col_beat_f(col_beat_f),
        .data_valid(data_valid), .data_block(data_block), .data_ready(data_ready),
        .data_frame(data_frame), .data_beat_r(data_beat_r), .data_beat_f(data_beat_f)
    );

    pbs_tx #(.DATA_CHECK(1'b1)) i_pbs_tx_ecc (
        .clk(clk), .rst(rst),
        .row_valid(1'b0), .row_addr(12'd0), .row_ready(e_row_ready),
        .row_frame(e_row_frame), .row_beat_r(e_row_r), .row_beat_f(e_row_f),
        .col_valid(1'b0), .col_addr(20'd0), .col_ready(e_col_ready),
        .col_frame(e_col_frame), .col_beat_r(e_col_r), .col_beat_f(e_col_f),
        .data_valid(e_valid), .data_block(e_block), .data_ready(e_ready),
        .data_frame(e_frame), .data_beat_r(e_beat_r), .data_beat_f(e_beat_f)
    );

    // Lane ids: 0 row, 1 column, 2 data (16), 3 data with check bits (18).
    function automatic int lane_w(input int lane);
        case (lane)
            0: return 3;
            1: return 5;
            2: return 16;
            default: return 18;
        endcase
    endfunction

    function automatic logic [143:0] slice_of(input logic [143:0] p, input int lane, input int i);
        logic [143:0] mask;
        mask = (144'd1 << lane_w(lane)) - 144'd1;
        return (p >> (i * lane_w(lane))) & mask;
    endfunction

    function automatic logic [143:0] pattern(input int seed, input int lane);
        logic [143:0] p;
        for (int j = 0; j < 5; j++) begin
            p[j*32 +: 32] = 32'h9E37_79B9 * 32'(seed * 7 + j + 1) ^ 32'(seed << j);
        end
        case (lane)
            0: return p & 144'hFFF;
            1: return p & 144'hF_FFFF;
            2: return p & {16'd0, {128{1'b1}}};
            default: return p;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [143:0] act, input logic [143:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_in(input int lane, input logic v, input logic [143:0] p);
        case (lane)
            0: begin row_valid = v;  row_addr = p[11:0];    end
            1: begin col_valid = v;  col_addr = p[19:0];    end
            2: begin data_valid = v; data_block = p[127:0]; end
            default: begin e_valid = v; e_block = p; end
        endcase
    endtask

    task automatic get_out(input int lane, output logic fr, output logic rd,
                           output logic [143:0] br, output logic [143:0] bf);
        case (lane)
            0: begin fr = row_frame;  rd = row_ready;  br = 144'(row_beat_r);  bf = 144'(row_beat_f);  end
            1: begin fr = col_frame;  rd = col_ready;  br = 144'(col_beat_r);  bf = 144'(col_beat_f);  end
            2: begin fr = data_frame; rd = data_ready; br = 144'(data_beat_r); bf = 144'(data_beat_f); end
            default: begin fr = e_frame; rd = e_ready; br = 144'(e_beat_r); bf = 144'(e_beat_f); end
        endcase
    endtask

    // Checks one packet cycle k of payload p (R2 frame, R6 ready, R3/R4/R5 slices).
    task automatic chk_cycle(input int lane, input int k, input logic [143:0] p, input string tag);
        logic fr, rd;
        logic [143:0] br, bf;
        get_out(lane, fr, rd, br, bf);
        chk("R2", "frame in packet", 144'(fr), 144'd1);
        chk("R6", "ready in packet", 144'(rd), 144'(k == 3));
        chk(tag, "rising beat", br, slice_of(p, lane, 2 * k));
        chk(tag, "falling beat", bf, slice_of(p, lane, 2 * k + 1));
    endtask

    task automatic chk_idle(input int lane);
        logic fr, rd;
        logic [143:0] br, bf;
        get_out(lane, fr, rd, br, bf);
        chk("R2", "frame after packet", 144'(fr), 144'd0);
        chk("R6", "ready when idle", 144'(rd), 144'd1);
        chk("R9", "beats when idle", br | bf, 144'd0);
    endtask

    task automatic run_pkt(input int lane, input logic [143:0] p, input string tag);
        @(negedge clk);
        set_in(lane, 1'b1, p);
        @(negedge clk);
        set_in(lane, 1'b0, '0);
        for (int k = 0; k < 4; k++) begin
            chk_cycle(lane, k, p, tag);
            if (k < 3) @(negedge clk);
        end
        @(negedge clk);
        chk_idle(lane);
    endtask

    // R7: a different payload held while not ready must be ignored; then
    // the next request is taken in cycle 3 and follows with no gap (R2).
    task automatic run_b2b(input int lane, input logic [143:0] a,
                           input logic [143:0] junk, input logic [143:0] b, input string tag);
        @(negedge clk);
        set_in(lane, 1'b1, a);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            set_in(lane, 1'b1, (k == 3) ? b : junk);
            chk_cycle(lane, k, a, tag);
            if (k < 3) @(negedge clk);
        end
        @(negedge clk);
        set_in(lane, 1'b0, '0);
        for (int k = 0; k < 4; k++) begin
            chk_cycle(lane, k, b, "R7");
            if (k < 3) @(negedge clk);
        end
        @(negedge clk);
        chk_idle(lane);
    endtask

    function automatic string lane_tag(input int lane);
        return (lane < 2) ? "R3,R4" : "R3,R5";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: state during and right after reset.
        repeat (3) @(negedge clk);
        for (int l = 0; l < 4; l++) chk_idle(l);
        rst = 1'b0;
        @(negedge clk);
        for (int l = 0; l < 4; l++) begin
            logic fr, rd;
            logic [143:0] br, bf;
            get_out(l, fr, rd, br, bf);
            chk("R1", "frame after reset", 144'(fr), 144'd0);
            chk("R1", "ready after reset", 144'(rd), 144'd1);
            chk("R1", "beats after reset", br | bf, 144'd0);
        end

        // Exhaustive row addresses (R4: upper slices zero).
        for (int a = 0; a < 4096; a++) run_pkt(0, 144'(a), "R3,R4");

        // Column: walking ones and mixed patterns.
        for (int b = 0; b < 20; b++) run_pkt(1, 144'd1 << b, "R3,R4");
        for (int s = 0; s < 64; s++) run_pkt(1, pattern(s, 1), "R3,R4");

        // Data lanes: walking ones over the full block, then patterns (R5).
        for (int b = 0; b < 128; b++) run_pkt(2, 144'd1 << b, "R3,R5");
        for (int b = 0; b < 144; b++) run_pkt(3, 144'd1 << b, "R3,R5");
        for (int s = 0; s < 32; s++) begin
            run_pkt(2, pattern(s, 2), "R3,R5");
            run_pkt(3, pattern(s, 3), "R3,R5");
        end

        // R7 and gapless back-to-back packets on every lane.
        for (int l = 0; l < 4; l++) begin
            for (int s = 0; s < 8; s++) begin
                run_b2b(l, pattern(3 * s, l), pattern(3 * s + 1, l), pattern(3 * s + 2, l), "R7");
            end
        end

        // R8: all lanes busy at once with distinct payloads.
        for (int s = 0; s < 24; s++) begin
            fork
                run_pkt(0, pattern(s + 100, 0), "R8");
                run_pkt(1, pattern(s + 200, 1), "R8");
                run_pkt(2, pattern(s + 300, 2), "R8");
                run_pkt(3, pattern(s + 400, 3), "R8");
            join
        end

        // R8: staggered starts, one lane back-to-back beside single packets.
        fork
            run_b2b(2, pattern(7, 2), pattern(8, 2), pattern(9, 2), "R8");
            begin @(negedge clk); run_pkt(0, pattern(11, 0), "R8"); end
            begin repeat (2) @(negedge clk); run_pkt(1, pattern(12, 1), "R8"); end
        join

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule